// File: doc/BRIEF.md
# Accumulator Sequencer Core

This block is a small stored-program processor. One 32-byte memory inside the block holds both code and data. All arithmetic goes through a single 8-bit accumulator. Each memory access passes through an address latch and a data latch. A multicycle sequencer runs every instruction as a fixed series of register transfers: fetch the word at the program counter, decode it, fetch or write an operand if the instruction needs one, then execute. The word format is an opcode in bits [7:5] and an address in bits [4:0].

While the core is held in reset, a host fills the memory through a valid/ready preload port. The port is ready only during reset, and a byte is written on every cycle in which valid and ready are both high. Valid is ignored while ready is low, so the host never needs back-pressure handling beyond waiting for reset. After reset is released the core runs from address 0 until it executes a halt. It then raises a halted flag and holds still until the next reset. Debug outputs show the program counter and the accumulator.

Top module: `acc_core`

## Requirements
- R1: Synchronous reset clears the program counter, accumulator and instruction state, so that pc_dbg=0, acc_dbg=0 and halted=0 while reset is held. When reset is released the core starts fetching at address 0.
- R2: ld_ready equals rst. A byte ld_data is written to address ld_addr on each clock edge where ld_valid and ld_ready are both 1. ld_valid has no effect while the core runs.
- R3: Every instruction first fetches the word at the program counter. The opcode sits in bits [7:5] and the operand address in bits [4:0], with encodings 0 halt, 1 load, 2 store, 3 add, 4 subtract, 5 branch, 6 branch-if-zero, 7 branch-if-positive.
- R4: Load copies the memory byte at the operand address into the accumulator and advances the program counter by one.
- R5: Add and subtract combine the accumulator with the memory byte at the operand address, modulo 256, and advance the program counter by one.
- R6: Store writes the accumulator to memory at the operand address, where a later load reads it back.
- R7: An unconditional branch loads the program counter with the operand address.
- R8: Branch-if-zero is taken only when the accumulator is 0. Branch-if-positive is taken only when the accumulator is nonzero with bit 7 clear. A branch that is not taken advances the program counter by one.
- R9: Advancing the program counter from 31 gives 0.
- R10: After a halt is fetched, halted rises, the program counter keeps the halt's own address, and nothing changes until reset. A halt at address 0 raises halted on the 3rd clock edge after reset is released.
- R11: Load, store, add and subtract each take 6 cycles. Branches take 4 cycles. The program counter and accumulator change only in an instruction's last cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also opens the preload port |
| ld_valid | input | 1 | Preload byte is offered |
| ld_ready | output | 1 | Preload byte can be accepted (high only during reset) |
| ld_addr | input | 5 | Preload memory address |
| ld_data | input | 8 | Preload memory byte |
| halted | output | 1 | Core has executed a halt |
| pc_dbg | output | 5 | Program counter |
| acc_dbg | output | 8 | Accumulator |

## Verification
The hardest case to reach from the ports is the program counter wrapping past the top address. A program only gets there by running code placed in the last two bytes of memory. The stimulus uses a branch-if-zero at address 0, taken because the accumulator is zero right after reset, to jump to address 30. The code at 30 and 31 loads and adds, and the counter wraps to 0. There the same branch now falls through, because the accumulator is nonzero, and reaches a halt at address 1. The final PC of 1 and the accumulator value confirm both the wrap and the fall-through path.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPC_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_HLT = 3'd0,
    OP_LDA = 3'd1,
    OP_STA = 3'd2,
    OP_ADD = 3'd3,
    OP_SUB = 3'd4,
    OP_BR  = 3'd5,
    OP_BRZ = 3'd6,
    OP_BRP = 3'd7
  } opc_e;

  typedef enum logic [2:0] {
    S_FADDR,
    S_FREAD,
    S_DEC,
    S_OADDR,
    S_OREAD,
    S_EXEC,
    S_HALT
  } seq_e;
endpackage

// File: rtl/acc_ram.sv
module acc_ram #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  opc_e rd_op,
  output seq_e state
);
  seq_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      S_FADDR: nxt = S_FREAD;
      S_FREAD: nxt = S_DEC;
      S_DEC: begin
        case (rd_op)
          OP_HLT:                 nxt = S_HALT;
          OP_BR, OP_BRZ, OP_BRP:  nxt = S_EXEC;
          default:                nxt = S_OADDR;
        endcase
      end
      S_OADDR: nxt = S_OREAD;
      S_OREAD: nxt = S_EXEC;
      S_EXEC:  nxt = S_FADDR;
      S_HALT:  nxt = S_HALT;
      default: nxt = S_FADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_FADDR;
    else     state <= nxt;
  end

  // R1
  reset_entry_chk: assert property (@(posedge clk) rst |=> state == S_FADDR);

  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    state == S_HALT |=> state == S_HALT);
endmodule

// File: rtl/acc_dpath.sv
module acc_dpath
  import acc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_e              state,
  input  logic [DATA_W-1:0] rdata,
  output opc_e              ir_op,
  output opc_e              rd_op,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mdr,
  output logic [DATA_W-1:0] acc
);
  logic [DATA_W-1:0] ir;
  logic [ADDR_W-1:0] opnd;
  logic [ADDR_W-1:0] pc_inc;
  logic              acc_zero;
  logic              acc_pos;

  assign ir_op    = opc_e'(ir[DATA_W-1 -: OPC_W]);
  assign rd_op    = opc_e'(rdata[DATA_W-1 -: OPC_W]);
  assign opnd     = ir[ADDR_W-1:0];
  assign pc_inc   = pc + 1'b1;
  assign acc_zero = (acc == '0);
  assign acc_pos  = !acc_zero && !acc[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      ir  <= '0;
      mar <= '0;
      mdr <= '0;
      acc <= '0;
    end else begin
      case (state)
        S_FADDR: mar <= pc;
        S_DEC: begin
          ir  <= rdata;
          mdr <= rdata;
        end
        S_OADDR: begin
          mar <= opnd;
          if (ir_op == OP_STA) mdr <= acc;
        end
        S_EXEC: begin
          case (ir_op)
            OP_LDA: begin mdr <= rdata; acc <= rdata;       pc <= pc_inc; end
            OP_ADD: begin mdr <= rdata; acc <= acc + rdata; pc <= pc_inc; end
            OP_SUB: begin mdr <= rdata; acc <= acc - rdata; pc <= pc_inc; end
            OP_BR:  pc <= opnd;
            OP_BRZ: pc <= acc_zero ? opnd : pc_inc;
            OP_BRP: pc <= acc_pos  ? opnd : pc_inc;
            default: pc <= pc_inc;
          endcase
        end
        default: ;
      endcase
    end
  end

  // R3
  fetch_addr_chk: assert property (@(posedge clk) disable iff (rst)
    state == S_FADDR |=> mar == $past(pc));

  // R11
  acc_exec_only_chk: assert property (@(posedge clk) disable iff (rst)
    state != S_EXEC |=> $stable(acc));

  // R11
  pc_exec_only_chk: assert property (@(posedge clk) disable iff (rst)
    state != S_EXEC |=> $stable(pc));

  // R9
  pc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC && pc == '1 &&
     (ir_op == OP_LDA || ir_op == OP_STA || ir_op == OP_ADD || ir_op == OP_SUB))
    |=> pc == '0);
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int ADDR_W = 5,
  localparam int DATA_W = OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic              halted,
  output logic [ADDR_W-1:0] pc_dbg,
  output logic [DATA_W-1:0] acc_dbg
);
  seq_e              state;
  opc_e              ir_op;
  opc_e              rd_op;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mdr;
  logic [DATA_W-1:0] rdata;
  logic              host_we;
  logic              core_we;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;

  assign ld_ready  = rst;
  assign host_we   = ld_valid && ld_ready;
  assign core_we   = !rst && state == S_OREAD && ir_op == OP_STA;
  assign mem_we    = host_we || core_we;
  assign mem_waddr = host_we ? ld_addr : mar;
  assign mem_wdata = host_we ? ld_data : mdr;
  assign halted    = (state == S_HALT);

  acc_seq u_seq (
    .clk   (clk),
    .rst   (rst),
    .rd_op (rd_op),
    .state (state)
  );

  acc_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk   (clk),
    .rst   (rst),
    .state (state),
    .rdata (rdata),
    .ir_op (ir_op),
    .rd_op (rd_op),
    .pc    (pc_dbg),
    .mar   (mar),
    .mdr   (mdr),
    .acc   (acc_dbg)
  );

  acc_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mar),
    .rdata (rdata)
  );

  // R2
  preload_gate_chk: assert property (@(posedge clk)
    !rst |-> !(mem_we && mem_waddr == ld_addr && host_we));

  // R6
  store_state_chk: assert property (@(posedge clk) disable iff (rst)
    core_we |-> $past(state) == S_OADDR);
endmodule

// File: tb/test_acc_core.sv
module test_acc_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld_valid = 1'b0;
  logic       ld_ready;
  logic [4:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic       halted;
  logic [4:0] pc_dbg;
  logic [7:0] acc_dbg;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  logic [7:0] prog [32];

  always #5 clk = ~clk;

  acc_core i_acc_core (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data), .halted(halted),
    .pc_dbg(pc_dbg), .acc_dbg(acc_dbg)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [7:0] ins(input int op, input int a);
    return 8'((op << 5) | (a & 31));
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 32; i++) prog[i] = 8'h00;
  endtask

  // hold reset, preload all 32 bytes, release at a negedge
  task automatic boot();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 32; i++) begin
      ld_valid = 1'b1; ld_addr = 5'(i); ld_data = prog[i];
      @(negedge clk);
    end
    ld_valid = 1'b0;
    rst = 1'b0;
  endtask

  task automatic run(output int n);
    n = 0;
    while (!halted && n < 500) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    int n;
    clear_prog();
    prog[0] = ins(1, 5); prog[1] = 8'h00; prog[5] = 8'h3C;
    boot(); run(n);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 pc in reset", pc_dbg, 0);
    chk("R1 acc in reset", acc_dbg, 0);
    chk("R1 halted in reset", halted, 0);
    chk("R2 ready in reset", ld_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 ready while running", ld_ready, 0);
  endtask

  task automatic t_timing();
    int n;
    clear_prog();
    boot(); run(n);
    chk("R10 halt cycles", n, 3);
    chk("R10 halt pc", pc_dbg, 0);
    repeat (10) @(negedge clk);
    chk("R10 halt held", halted, 1);
    chk("R10 pc held", pc_dbg, 0);
    clear_prog();
    prog[0] = ins(1, 7); prog[7] = 8'h12;
    boot(); run(n);
    chk("R11 load 6 cycles", n, 9);
    chk("R4 load value", acc_dbg, 8'h12);
    chk("R4 pc after load", pc_dbg, 1);
    clear_prog();
    prog[0] = ins(5, 1);
    boot(); run(n);
    chk("R11 branch 4 cycles", n, 7);
  endtask

  task automatic t_add_store();
    int n;
    clear_prog();
    prog[0] = ins(1, 10); prog[1] = ins(3, 11); prog[2] = ins(2, 12);
    prog[3] = ins(1, 13); prog[4] = ins(1, 12);
    prog[10] = 8'd200; prog[11] = 8'd100; prog[13] = 8'd7;
    boot(); run(n);
    chk("R5 R6 add wrap and store readback", acc_dbg, 44);
    chk("R6 pc", pc_dbg, 5);
  endtask

  task automatic t_sub();
    int n;
    clear_prog();
    prog[0] = ins(1, 10); prog[1] = ins(4, 11);
    prog[10] = 8'd5; prog[11] = 8'd7;
    boot(); run(n);
    chk("R5 sub wrap", acc_dbg, 254);
    chk("R5 pc", pc_dbg, 2);
  endtask

  task automatic t_branch();
    int n;
    clear_prog();
    prog[0]  = ins(1, 20); prog[1]  = ins(6, 4);  prog[2] = ins(1, 21);
    prog[4]  = ins(7, 7);  prog[5]  = ins(1, 22); prog[6] = ins(7, 9);
    prog[9]  = ins(1, 23); prog[10] = ins(7, 12); prog[11] = ins(6, 13);
    prog[12] = ins(5, 15);
    prog[20] = 8'h00; prog[21] = 8'h55; prog[22] = 8'h05; prog[23] = 8'h80;
    boot(); run(n);
    chk("R7 R8 branch path pc", pc_dbg, 15);
    chk("R8 branch path acc", acc_dbg, 8'h80);
  endtask

  task automatic t_wrap();
    int n;
    clear_prog();
    prog[0] = ins(6, 30); prog[28] = 8'h01; prog[29] = 8'h33;
    prog[30] = ins(1, 29); prog[31] = ins(3, 28);
    boot(); run(n);
    chk("R9 wrap pc", pc_dbg, 1);
    chk("R9 wrap acc", acc_dbg, 8'h34);
  endtask

  task automatic t_preload_ignored();
    int n;
    clear_prog();
    prog[0] = ins(1, 10); prog[10] = 8'h11;
    boot();
    ld_valid = 1'b1; ld_addr = 5'd10; ld_data = 8'h99;
    repeat (3) @(negedge clk);
    ld_valid = 1'b0;
    run(n);
    chk("R2 valid ignored while running", acc_dbg, 8'h11);
  endtask

  initial begin
    t_reset();
    t_timing();
    t_add_store();
    t_sub();
    t_branch();
    t_wrap();
    t_preload_ignored();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule